// File: doc/BRIEF.md
# Programmable-Priority Preemptive Channel Arbiter

This block chooses which of sixteen transfer channels owns the shared transfer engine. Each channel carries a 4-bit priority chosen by software and a bit that says whether the channel may be interrupted. In priority mode, the requesting channel with the largest priority value is granted. A running channel that allows interruption gives way to a request whose priority is strictly higher. The interrupted channel is parked in a single holding slot. It gets the engine back when the interrupting channel reports completion.

Software must give every channel a different priority. When two channels share a value, a sticky configuration error is raised. No new grant or interruption is made until software clears the error and the values are unique again. A rotating mode can replace priority mode. It hands the grant to the next requesting channel after the last one served, ignores the programmed values and never interrupts. A stop-mode input masks every channel whose stop-mode wake enable is 0.

Top module: `prio_chan_arb`

## Requirements
- R1: While `stopMode` is 1, a request from channel i is ignored unless `stopWakeEn[i]` is 1. While `stopMode` is 0, all requests count.
- R2: In priority mode (`rrMode`=0), an idle arbiter grants the counted request whose priority field `prioFlat[4i+3:4i]` is numerically largest. Value 0 is the lowest priority.
- R3: `grantValid` is 1 exactly when a channel holds the grant. `grantOneHot` then has only bit i set for the granted channel i, and is all zero otherwise. Grant changes take effect at the clock edge that samples the causing request or done strobe.
- R4: `cfgErr` is set at the edge after two channels hold equal priority fields in priority mode. It stays set until `errClear` is 1 in a cycle with no duplicate present.
- R5: While `cfgErr` is 1, or while a duplicate exists in priority mode, no new grant and no interruption occurs. A grant already held continues until done.
- R6: In priority mode, if the granted channel has `preemptEn`=1 and the holding slot is empty, a counted request with strictly higher priority takes the grant at the next edge. At that edge `suspendValid` becomes 1 and `suspendCh` shows the interrupted channel.
- R7: A granted channel with `preemptEn`=0 is never interrupted.
- R8: While `suspendValid` is 1, the granted channel cannot be interrupted, and the grant and `suspendCh` stay unchanged until `chDone`.
- R9: `chDone` while a channel is suspended moves the grant back to the suspended channel at the next edge and clears `suspendValid`.
- R10: `chDone` with an empty holding slot drops the grant at the next edge. Arbitration resumes in the following cycle.
- R11: In rotating mode (`rrMode`=1), an idle arbiter grants the first counted request after the last granted channel, in ascending index order with wrap-around. After reset the search starts at channel 0. No interruption occurs in this mode.
- R12: `chDone` while no channel is granted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqVec | input | 16 | Service request per channel |
| prioFlat | input | 64 | Priority of channel i in bits 4i+3:4i |
| preemptEn | input | 16 | Channel i may be interrupted when its bit is 1 |
| stopWakeEn | input | 16 | Channel i request counts in stop mode when its bit is 1 |
| stopMode | input | 1 | Stop mode is active |
| rrMode | input | 1 | 1 selects rotating mode, 0 selects priority mode |
| chDone | input | 1 | Granted channel finished its service |
| errClear | input | 1 | Clears the configuration error (write-one-to-clear) |
| grantOneHot | output | 16 | One-hot grant |
| grantValid | output | 1 | A channel holds the grant |
| suspendValid | output | 1 | A channel is parked in the holding slot |
| suspendCh | output | 4 | Index of the parked channel |
| cfgErr | output | 1 | Sticky duplicate-priority error |

## Verification
The bench targets these corner cases:

- An interrupting channel that is itself challenged by a still higher request. A design that nested a second interruption would overwrite the holding slot and lose the parked channel.
- A done strobe with a channel parked. A design that arbitrated again instead of resuming would hand the engine to a fresh requester.
- A duplicate created and cleared while a channel runs. A design that let the error cut the running grant, or dropped the error on a clear while the duplicate remains, shows up at once.
- Rotation wrap-around and stop-mode masking. An off-by-one in the pointer would serve the last channel again, and a missing mask would grant a sleeping channel.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic grantNew;   // idle arbiter picks the candidate
    logic preempt;    // candidate displaces active channel, active is parked
    logic resume;     // parked channel takes the grant back
    logic drop;       // active channel finished with nothing parked
  } arbStrb_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  input  logic [NUM_CH-1:0]        preemptEn,
  input  logic [NUM_CH-1:0]        stopWakeEn,
  input  logic                     stopMode,
  input  logic                     rrMode,
  input  logic                     errClear,
  input  arbStrb_t                 strb,
  output logic                     candValid,
  output logic                     candBeats,
  output logic                     activePreemptOk,
  output logic                     dupNow,
  output logic                     cfgErr,
  output logic [$clog2(NUM_CH)-1:0] activeCh,
  output logic [$clog2(NUM_CH)-1:0] heldCh
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [PRIO_W-1:0] prio [NUM_CH];
  logic [NUM_CH-1:0] effReq;
  logic [CH_W-1:0]   lastCh;
  logic              fixValid, rrValid;
  logic [CH_W-1:0]   fixCh, rrCh, candCh;
  logic [PRIO_W-1:0] fixPrio;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign prio[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  assign effReq = reqVec & (stopMode ? stopWakeEn : '1);

  // pairwise duplicate search
  always_comb begin
    dupNow = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      for (int j = i + 1; j < NUM_CH; j++)
        if (prio[i] == prio[j]) dupNow = 1'b1;
  end

  // largest priority value among counted requests
  always_comb begin
    fixValid = 1'b0;
    fixCh    = '0;
    fixPrio  = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (effReq[i] && (!fixValid || prio[i] > fixPrio)) begin
        fixValid = 1'b1;
        fixCh    = CH_W'(i);
        fixPrio  = prio[i];
      end
  end

  // first counted request after the rotation pointer
  always_comb begin
    rrValid = 1'b0;
    rrCh    = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(lastCh) + k) % NUM_CH;
      if (!rrValid && effReq[idx]) begin
        rrValid = 1'b1;
        rrCh    = CH_W'(idx);
      end
    end
  end

  assign candValid       = rrMode ? rrValid : fixValid;
  assign candCh          = rrMode ? rrCh : fixCh;
  assign candBeats       = fixValid && (fixPrio > prio[activeCh]);
  assign activePreemptOk = preemptEn[activeCh];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeCh <= '0;
      heldCh   <= '0;
      lastCh   <= CH_W'(NUM_CH - 1);
      cfgErr   <= 1'b0;
    end else begin
      cfgErr <= (dupNow & ~rrMode) | (cfgErr & ~errClear);
      if (strb.grantNew) begin
        activeCh <= candCh;
        lastCh   <= candCh;
      end else if (strb.preempt) begin
        heldCh   <= activeCh;
        activeCh <= candCh;
        lastCh   <= candCh;
      end else if (strb.resume) begin
        activeCh <= heldCh;
      end
    end
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgErr && !errClear) |=> cfgErr);

  // R6
  preempt_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.preempt |=> $past(preemptEn[activeCh]) && heldCh == $past(activeCh));
endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chDone,
  input  logic     rrMode,
  input  logic     candValid,
  input  logic     candBeats,
  input  logic     activePreemptOk,
  input  logic     cfgErr,
  input  logic     dupNow,
  output arbStrb_t strb,
  output logic     active,
  output logic     heldValid
);
  logic blocked;

  assign blocked = cfgErr | (dupNow & ~rrMode);

  always_comb begin
    strb = '0;
    if (active && chDone) begin
      if (heldValid) strb.resume = 1'b1;
      else           strb.drop   = 1'b1;
    end else if (!active) begin
      strb.grantNew = candValid & ~blocked;
    end else begin
      strb.preempt = ~rrMode & ~heldValid & activePreemptOk & candBeats & ~blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      heldValid <= 1'b0;
    end else begin
      if (strb.grantNew)      active <= 1'b1;
      else if (strb.drop)     active <= 1'b0;
      if (strb.preempt)       heldValid <= 1'b1;
      else if (strb.resume)   heldValid <= 1'b0;
    end
  end

  // R5
  no_grant_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && cfgErr) |=> !active);

  // R11
  rr_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rrMode && !heldValid) |=> !heldValid);

  // R12
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !candValid) |=> !active);
endmodule

// File: rtl/prio_chan_arb.sv
module prio_chan_arb
  import arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int PRIO_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         reqVec,
  input  logic [NUM_CH*PRIO_W-1:0]  prioFlat,
  input  logic [NUM_CH-1:0]         preemptEn,
  input  logic [NUM_CH-1:0]         stopWakeEn,
  input  logic                      stopMode,
  input  logic                      rrMode,
  input  logic                      chDone,
  input  logic                      errClear,
  output logic [NUM_CH-1:0]         grantOneHot,
  output logic                      grantValid,
  output logic                      suspendValid,
  output logic [$clog2(NUM_CH)-1:0] suspendCh,
  output logic                      cfgErr
);
  localparam int CH_W = $clog2(NUM_CH);

  arbStrb_t        strb;
  logic            candValid, candBeats, activePreemptOk, dupNow;
  logic            active, heldValid;
  logic [CH_W-1:0] activeCh, heldCh;

  arb_datapath #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .prioFlat(prioFlat),
    .preemptEn(preemptEn), .stopWakeEn(stopWakeEn), .stopMode(stopMode),
    .rrMode(rrMode), .errClear(errClear), .strb(strb),
    .candValid(candValid), .candBeats(candBeats),
    .activePreemptOk(activePreemptOk), .dupNow(dupNow), .cfgErr(cfgErr),
    .activeCh(activeCh), .heldCh(heldCh)
  );

  arb_control u_ctl (
    .clk(clk), .rst_n(rst_n), .chDone(chDone), .rrMode(rrMode),
    .candValid(candValid), .candBeats(candBeats),
    .activePreemptOk(activePreemptOk), .cfgErr(cfgErr), .dupNow(dupNow),
    .strb(strb), .active(active), .heldValid(heldValid)
  );

  always_comb begin
    grantOneHot = '0;
    if (active) grantOneHot[activeCh] = 1'b1;
  end

  assign grantValid   = active;
  assign suspendValid = heldValid;
  assign suspendCh    = heldCh;

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantOneHot) && (grantValid == (grantOneHot != '0)));

  // R7
  no_preempt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !suspendValid && !preemptEn[activeCh] && !chDone) |=> !suspendValid);

  // R8
  held_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspendValid && !chDone) |=> suspendValid && $stable(suspendCh) && $stable(grantOneHot));

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspendValid && chDone) |=> grantValid && !suspendValid && grantOneHot[$past(suspendCh)]);
endmodule

// File: tb/tb_prio_chan_arb.sv
`timescale 1ns/1ps
module tb_prio_chan_arb;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  reqVec = '0;
  logic [NCH*4-1:0] prioFlat = '0;
  logic [NCH-1:0]  preemptEn = '0;
  logic [NCH-1:0]  stopWakeEn = '0;
  logic            stopMode = 1'b0;
  logic            rrMode = 1'b0;
  logic            chDone = 1'b0;
  logic            errClear = 1'b0;
  logic [NCH-1:0]  grantOneHot;
  logic            grantValid, suspendValid, cfgErr;
  logic [3:0]      suspendCh;

  prio_chan_arb dut (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .prioFlat(prioFlat),
    .preemptEn(preemptEn), .stopWakeEn(stopWakeEn), .stopMode(stopMode),
    .rrMode(rrMode), .chDone(chDone), .errClear(errClear),
    .grantOneHot(grantOneHot), .grantValid(grantValid),
    .suspendValid(suspendValid), .suspendCh(suspendCh), .cfgErr(cfgErr)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  bit       mActive, mHeld, mErr;
  int       mCh, mHeldCh, mLast;
  string    evTag;

  function automatic int pr(int i);
    return int'(prioFlat[i*4 +: 4]);
  endfunction

  function automatic bit hasDup();
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (pr(i) == pr(j)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelReset();
    mActive = 0; mHeld = 0; mErr = 0; mCh = 0; mHeldCh = 0; mLast = NCH - 1;
  endtask

  task automatic modelStep();
    logic [NCH-1:0] eff;
    bit dup, blk, fv, rv;
    int fc, fp, rc;
    eff = reqVec & (stopMode ? stopWakeEn : {NCH{1'b1}});
    dup = hasDup();
    blk = mErr | (dup & ~rrMode);
    fv = 0; fc = 0; fp = 0;
    for (int i = 0; i < NCH; i++)
      if (eff[i] && (!fv || pr(i) > fp)) begin fv = 1; fc = i; fp = pr(i); end
    rv = 0; rc = 0;
    for (int k = 1; k <= NCH; k++)
      if (!rv && eff[(mLast + k) % NCH]) begin rv = 1; rc = (mLast + k) % NCH; end
    evTag = (stopMode && ((reqVec & ~stopWakeEn) != '0)) ? "R1" : "R3";
    if (mActive && chDone) begin
      if (mHeld) begin mCh = mHeldCh; mHeld = 0; evTag = "R9"; end
      else begin mActive = 0; evTag = "R10"; end
    end else if (!mActive) begin
      if (chDone) evTag = "R12";
      if (rrMode ? rv : fv) begin
        if (blk) evTag = "R5";
        else begin
          mActive = 1; mCh = rrMode ? rc : fc; mLast = mCh;
          evTag = rrMode ? "R11" : "R2";
        end
      end
    end else if (!rrMode && fv && fp > pr(mCh)) begin
      if (blk)             evTag = "R5";
      else if (mHeld)      evTag = "R8";
      else if (!preemptEn[mCh]) evTag = "R7";
      else begin
        mHeldCh = mCh; mHeld = 1; mCh = fc; mLast = fc; evTag = "R6";
      end
    end
    mErr = (dup & ~rrMode) | (mErr & ~errClear);
  endtask

  task automatic compare();
    logic [NCH-1:0] expOh;
    expOh = mActive ? (NCH'(1) << mCh) : '0;
    nChecks++;
    if (grantValid !== mActive || grantOneHot !== expOh) begin
      nFails++;
      $display("FAIL %s grant: got v=%0b oh=%h exp v=%0b oh=%h", evTag,
               grantValid, grantOneHot, mActive, expOh);
    end
    nChecks++;
    if (suspendValid !== mHeld || (mHeld && suspendCh !== 4'(mHeldCh))) begin
      nFails++;
      $display("FAIL %s suspend: got v=%0b ch=%0d exp v=%0b ch=%0d", evTag,
               suspendValid, suspendCh, mHeld, mHeldCh);
    end
    nChecks++;
    if (cfgErr !== mErr) begin
      nFails++;
      $display("FAIL R4 cfgErr: got %0b exp %0b", cfgErr, mErr);
    end
  endtask

  // inputs already driven (at a negedge); advance one edge and compare
  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic setIdentityPrio();
    for (int i = 0; i < NCH; i++) prioFlat[i*4 +: 4] = 4'(i);
  endtask

  task automatic shufflePrio();
    int p [NCH];
    for (int i = 0; i < NCH; i++) p[i] = i;
    for (int i = NCH - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = p[i]; p[i] = p[j]; p[j] = t;
    end
    for (int i = 0; i < NCH; i++) prioFlat[i*4 +: 4] = 4'(p[i]);
  endtask

  initial begin
    #(5 * 190000);
    $display("FAIL watchdog: got timeout exp finish");
    nChecks++; nFails++;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    setIdentityPrio();
    repeat (3) @(negedge clk);
    // R3: reset state
    compare();
    rst_n = 1'b1;
    @(negedge clk);

    // R2: highest value wins
    reqVec = 16'h0028; cycle();           // ch5 granted
    // R12 style: hold then done, drop then regrant
    preemptEn = 16'hFFFF;
    reqVec = 16'h0008; chDone = 1'b1; cycle(); // R10 drop
    chDone = 1'b0; cycle();                    // ch3
    // R6: higher request interrupts
    reqVec = 16'h0408; cycle();                // ch10 preempts 3
    // R8: still higher while parked
    reqVec = 16'h4408; cycle(); cycle();
    // R9: done resumes ch3
    reqVec = 16'h0008; chDone = 1'b1; cycle();
    chDone = 1'b0; cycle();
    // R7: locked channel
    preemptEn = 16'h0000; reqVec = 16'h8008; cycle(); cycle();
    chDone = 1'b1; cycle(); chDone = 1'b0; cycle(); // ch15 granted
    chDone = 1'b1; reqVec = '0; cycle(); chDone = 1'b0;
    // R12: done while idle
    chDone = 1'b1; cycle(); chDone = 1'b0; cycle();
    // R4/R5: duplicate
    prioFlat[0 +: 4] = 4'd7; reqVec = 16'h0001; cycle(); cycle();
    errClear = 1'b1; cycle(); errClear = 1'b0; cycle(); // dup remains
    setIdentityPrio(); cycle(); // still sticky
    errClear = 1'b1; cycle(); errClear = 1'b0; cycle(); cycle(); // ch0 granted
    chDone = 1'b1; reqVec = '0; cycle(); chDone = 1'b0;
    // R1: stop mode masking
    stopMode = 1'b1; stopWakeEn = 16'h0002; reqVec = 16'h8002; cycle(); cycle();
    chDone = 1'b1; reqVec = '0; cycle(); chDone = 1'b0; stopMode = 1'b0;
    // R11: rotation with wrap
    rrMode = 1'b1; preemptEn = '1; reqVec = 16'h8001;
    for (int n = 0; n < 6; n++) begin
      chDone = 1'b0; cycle();
      chDone = 1'b1; cycle();
    end
    chDone = 1'b0; rrMode = 1'b0; reqVec = '0; cycle();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if (n % 150 == 0) begin
        shufflePrio();
        preemptEn = 16'($urandom);
        stopWakeEn = 16'($urandom);
        if ($urandom % 8 == 0) prioFlat[4*($urandom % NCH) +: 4] = 4'($urandom);
      end
      if (n % 500 == 0) rrMode = ($urandom % 3 == 0);
      if (n % 60 == 0) stopMode = ($urandom % 4 == 0);
      if ($urandom % 3 == 0) reqVec = 16'($urandom & $urandom & $urandom);
      chDone   = ($urandom % 5 == 0);
      errClear = ($urandom % 12 == 0);
      cycle();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule